// File: doc/BRIEF.md
# Interrupt and Break Entry Sequencer

This block carries out the multi-cycle entry into an exception handler for a byte-wide processor core. Three kinds of entry share one sequence: a maskable interrupt, a non-maskable interrupt and a software break. In each case the block saves the return address, high byte first, on a stack that lives in a fixed 256-byte page. It then saves the packed status byte, raises the interrupt-disable flag, and loads a new program counter from a two-byte vector, low byte first.

The surrounding core decides when an entry is taken. It pulses `start_i` with the kind of entry, and for that cycle it supplies the current PC and SP. While the sequence runs, the block owns the memory bus. The block keeps its own working copies of PC and SP and shows them on `pc_o` and `sp_o`. After the single-cycle `done_o` pulse, `pc_o` holds the handler address.

A software break can be taken over by a non-maskable interrupt. If the pending-NMI latch is set in the cycle that pushes the break's status byte, the block clears that latch and fetches the NMI vector in place of the break vector. A break that completes normally flags a hold-off of NMI recognition during its vector-low cycle.

Top module: `intr_entry_seq`

## Requirements
- R1: After reset the block is idle: `busy_o`, `we_o`, `done_o`, `i_set_o`, `nmi_clr_o` and `nmi_delay_o` are all 0.
- R2: For kinds 0 (maskable) and 1 (non-maskable), the block runs seven bus cycles, starting in the cycle after `start_i` is sampled. The cycles are:
  - two reads at the captured PC;
  - write PC high;
  - write PC low;
  - write status;
  - read vector low;
  - read vector high.
- R3: Each push writes to address {STACK_PAGE, SP} and then decrements SP by one, wrapping inside the page. After an entry, `sp_o` equals the start SP minus 3.
- R4: The pushed status byte is {N, V, 1, B, D, I, Z, C}, bit 7 down to bit 0. I is the value before the entry. B is 0 for kinds 0 and 1 and 1 for kind 2 (break).
- R5: `i_set_o` is high in the status-push cycle and in no other cycle.
- R6: Kinds 0 and 2 read their vector from IRQ_VEC and IRQ_VEC+1. Kind 1 reads from NMI_VEC and NMI_VEC+1. From the cycle after `done_o`, `pc_o` equals {high byte read, low byte read}.
- R7: A break (kind 2) makes one read at the captured PC and advances PC by one. The pushed return address is therefore PC+1, and the entry takes six bus cycles.
- R8: If `nmi_pend_i` is 1 in a break's status-push cycle, `nmi_clr_o` pulses in that cycle and the NMI vector is read. For kinds 0 and 1, `nmi_pend_i` has no effect.
- R9: A break that is not taken over raises `nmi_delay_o` in its vector-low cycle only. A break that is taken over never raises it.
- R10: `done_o` is a one-cycle pulse in the vector-high cycle, and the block is idle in the next cycle.
- R11: `start_i` is ignored while a sequence is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin an entry (sampled while idle) |
| kind_i | input | 2 | Entry kind: 0 maskable, 1 non-maskable, 2 break, 3 treated as 0 |
| pc_i | input | 16 | Current PC, captured at start |
| sp_i | input | 8 | Current SP, captured at start |
| flag_n_i | input | 1 | Negative flag |
| flag_v_i | input | 1 | Overflow flag |
| flag_d_i | input | 1 | Decimal flag |
| flag_i_i | input | 1 | Interrupt-disable flag |
| flag_z_i | input | 1 | Zero flag (1 = last result zero) |
| flag_c_i | input | 1 | Carry flag |
| nmi_pend_i | input | 1 | Pending non-maskable request latch |
| rdata_i | input | 8 | Memory read data for the current address |
| addr_o | output | 16 | Memory address |
| wdata_o | output | 8 | Memory write data |
| we_o | output | 1 | Memory write enable |
| pc_o | output | 16 | Working PC; the handler address after done |
| sp_o | output | 8 | Working SP |
| i_set_o | output | 1 | Set the interrupt-disable flag this cycle |
| nmi_clr_o | output | 1 | Clear the pending non-maskable latch |
| nmi_delay_o | output | 1 | Hold off non-maskable recognition this cycle |
| busy_o | output | 1 | A sequence is in progress |
| done_o | output | 1 | Last cycle of the sequence |

## Verification
The bench builds the block with its default parameters:
- stack page 0x01;
- maskable and break vector at 0xFFFE;
- non-maskable vector at 0xFFFA.

With those values, distinct vector contents let the bench tell the two vector pairs apart by the final PC. A start SP of 0x01 makes the third push wrap from 0x0100 to 0x01FF inside the page. A break at PC 0x30FF makes the skipped byte carry into the high byte of the pushed return address. A break is run both with and without a pending non-maskable request, to separate the takeover path from the normal one.

// File: rtl/intr_entry_pkg.sv
package intr_entry_pkg;

    localparam int SEQ_ADDR_W = 16;
    localparam int SEQ_DATA_W = 8;

    typedef enum logic [1:0] {
        KIND_IRQ = 2'd0,
        KIND_NMI = 2'd1,
        KIND_BRK = 2'd2
    } kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD1,
        ST_RD2,
        ST_PUSH_HI,
        ST_PUSH_LO,
        ST_PUSH_PSW,
        ST_VEC_LO,
        ST_VEC_HI
    } phase_e;

    typedef struct packed {
        phase_e                  phase;
        kind_e                   kind;
        logic                    use_nmi;
        logic [SEQ_ADDR_W-1:0]   pc;
        logic [SEQ_DATA_W-1:0]   sp;
    } seq_regs_t;

endpackage

// File: rtl/intr_status_pack.sv
module intr_status_pack
    import intr_entry_pkg::*;
(
    input  logic                  n_i,
    input  logic                  v_i,
    input  logic                  b_i,
    input  logic                  d_i,
    input  logic                  i_i,
    input  logic                  z_i,
    input  logic                  c_i,
    output logic [SEQ_DATA_W-1:0] psw_o
);
    // Fixed bit order: a stacked byte is decoded by the return path.
    always_comb begin
        psw_o    = '0;
        psw_o[7] = n_i;
        psw_o[6] = v_i;
        psw_o[5] = 1'b1;
        psw_o[4] = b_i;
        psw_o[3] = d_i;
        psw_o[2] = i_i;
        psw_o[1] = z_i;
        psw_o[0] = c_i;
    end
endmodule

// File: rtl/intr_vec_sel.sv
module intr_vec_sel
    import intr_entry_pkg::*;
#(
    parameter logic [SEQ_ADDR_W-1:0] IRQ_VEC = 16'hFFFE,
    parameter logic [SEQ_ADDR_W-1:0] NMI_VEC = 16'hFFFA
) (
    input  logic                  use_nmi_i,
    input  logic                  hi_i,
    output logic [SEQ_ADDR_W-1:0] addr_o
);
    logic [SEQ_ADDR_W-1:0] base;
    always_comb begin
        base   = use_nmi_i ? NMI_VEC : IRQ_VEC;
        addr_o = base + {{(SEQ_ADDR_W-1){1'b0}}, hi_i};
    end
endmodule

// File: rtl/intr_entry_seq.sv
module intr_entry_seq
    import intr_entry_pkg::*;
#(
    parameter logic [SEQ_DATA_W-1:0] STACK_PAGE = 8'h01,
    parameter logic [SEQ_ADDR_W-1:0] IRQ_VEC    = 16'hFFFE,
    parameter logic [SEQ_ADDR_W-1:0] NMI_VEC    = 16'hFFFA
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic [1:0]            kind_i,
    input  logic [SEQ_ADDR_W-1:0] pc_i,
    input  logic [SEQ_DATA_W-1:0] sp_i,
    input  logic                  flag_n_i,
    input  logic                  flag_v_i,
    input  logic                  flag_d_i,
    input  logic                  flag_i_i,
    input  logic                  flag_z_i,
    input  logic                  flag_c_i,
    input  logic                  nmi_pend_i,
    input  logic [SEQ_DATA_W-1:0] rdata_i,
    output logic [SEQ_ADDR_W-1:0] addr_o,
    output logic [SEQ_DATA_W-1:0] wdata_o,
    output logic                  we_o,
    output logic [SEQ_ADDR_W-1:0] pc_o,
    output logic [SEQ_DATA_W-1:0] sp_o,
    output logic                  i_set_o,
    output logic                  nmi_clr_o,
    output logic                  nmi_delay_o,
    output logic                  busy_o,
    output logic                  done_o
);
    localparam int HI_LSB = SEQ_ADDR_W - SEQ_DATA_W;
    localparam logic [SEQ_DATA_W-1:0] SP_STEP = 1;
    localparam logic [SEQ_ADDR_W-1:0] PC_STEP = 1;

    seq_regs_t r_d, r_q;

    logic                  is_brk;
    logic                  vec_hi;
    logic [SEQ_ADDR_W-1:0] vec_addr;
    logic [SEQ_DATA_W-1:0] psw;
    logic [SEQ_ADDR_W-1:0] stack_addr;

    assign is_brk     = (r_q.kind == KIND_BRK);
    assign stack_addr = {STACK_PAGE, r_q.sp};

    intr_status_pack u_pack (
        .n_i   (flag_n_i),
        .v_i   (flag_v_i),
        .b_i   (is_brk),
        .d_i   (flag_d_i),
        .i_i   (flag_i_i),
        .z_i   (flag_z_i),
        .c_i   (flag_c_i),
        .psw_o (psw)
    );

    intr_vec_sel #(
        .IRQ_VEC (IRQ_VEC),
        .NMI_VEC (NMI_VEC)
    ) u_vec (
        .use_nmi_i (r_q.use_nmi),
        .hi_i      (vec_hi),
        .addr_o    (vec_addr)
    );

    always_comb begin
        r_d         = r_q;
        addr_o      = r_q.pc;
        wdata_o     = '0;
        we_o        = 1'b0;
        i_set_o     = 1'b0;
        nmi_clr_o   = 1'b0;
        nmi_delay_o = 1'b0;
        done_o      = 1'b0;
        vec_hi      = 1'b0;
        unique case (r_q.phase)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.kind    = (kind_i == KIND_NMI) ? KIND_NMI :
                                  (kind_i == KIND_BRK) ? KIND_BRK : KIND_IRQ;
                    r_d.use_nmi = (kind_i == KIND_NMI);
                    r_d.pc      = pc_i;
                    r_d.sp      = sp_i;
                    r_d.phase   = ST_RD1;
                end
            end
            ST_RD1: begin
                if (is_brk) begin
                    r_d.pc    = r_q.pc + PC_STEP;
                    r_d.phase = ST_PUSH_HI;
                end else begin
                    r_d.phase = ST_RD2;
                end
            end
            ST_RD2: begin
                r_d.phase = ST_PUSH_HI;
            end
            ST_PUSH_HI: begin
                addr_o    = stack_addr;
                we_o      = 1'b1;
                wdata_o   = r_q.pc[SEQ_ADDR_W-1:HI_LSB];
                r_d.sp    = r_q.sp - SP_STEP;
                r_d.phase = ST_PUSH_LO;
            end
            ST_PUSH_LO: begin
                addr_o    = stack_addr;
                we_o      = 1'b1;
                wdata_o   = r_q.pc[SEQ_DATA_W-1:0];
                r_d.sp    = r_q.sp - SP_STEP;
                r_d.phase = ST_PUSH_PSW;
            end
            ST_PUSH_PSW: begin
                addr_o    = stack_addr;
                we_o      = 1'b1;
                wdata_o   = psw;
                i_set_o   = 1'b1;
                r_d.sp    = r_q.sp - SP_STEP;
                if (is_brk && nmi_pend_i) begin
                    nmi_clr_o   = 1'b1;
                    r_d.use_nmi = 1'b1;
                end
                r_d.phase = ST_VEC_LO;
            end
            ST_VEC_LO: begin
                addr_o                  = vec_addr;
                nmi_delay_o             = is_brk && !r_q.use_nmi;
                r_d.pc[SEQ_DATA_W-1:0]  = rdata_i;
                r_d.phase               = ST_VEC_HI;
            end
            ST_VEC_HI: begin
                vec_hi                         = 1'b1;
                addr_o                         = vec_addr;
                done_o                         = 1'b1;
                r_d.pc[SEQ_ADDR_W-1:HI_LSB]    = rdata_i;
                r_d.phase                      = ST_IDLE;
            end
            default: r_d.phase = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.phase   <= ST_IDLE;
            r_q.kind    <= KIND_IRQ;
            r_q.use_nmi <= 1'b0;
            r_q.pc      <= '0;
            r_q.sp      <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign pc_o   = r_q.pc;
    assign sp_o   = r_q.sp;
    assign busy_o = (r_q.phase != ST_IDLE);

    // R1: no bus write while idle
    a_r1_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !we_o);
    // R3: every push leaves SP one lower
    a_r3_push_decrements: assert property (@(posedge clk) disable iff (!rst_n)
        we_o |=> (sp_o == $past(sp_o) - SP_STEP));
    // R5: the disable flag is raised only together with a stack write
    a_r5_iset_on_push: assert property (@(posedge clk) disable iff (!rst_n)
        i_set_o |-> (we_o && addr_o[SEQ_ADDR_W-1:HI_LSB] == STACK_PAGE));
    // R8: a takeover is followed by the NMI vector fetch
    a_r8_clear_then_nmi_vec: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_clr_o |=> (addr_o == NMI_VEC && !we_o));
    // R9: the hold-off coincides with the break vector low read
    a_r9_delay_at_brk_vec: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_delay_o |-> (addr_o == IRQ_VEC && !we_o));
    // R10: done is a single pulse followed by idle
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

endmodule

// File: tb/intr_entry_seq_bench.sv
module intr_entry_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  kind_i = 2'd0;
    logic [15:0] pc_i = '0;
    logic [7:0]  sp_i = '0;
    logic        fn = 0, fv = 0, fd = 0, fi = 0, fz = 0, fc = 0;
    logic        nmi_pend_i = 1'b0;
    logic [7:0]  rdata_i;
    logic [15:0] addr_o, pc_o;
    logic [7:0]  wdata_o, sp_o;
    logic        we_o, i_set_o, nmi_clr_o, nmi_delay_o, busy_o, done_o;

    int total = 0;
    int failed = 0;

    always #4 clk = ~clk;

    always_comb begin
        case (addr_o)
            16'hFFFE: rdata_i = 8'h34;
            16'hFFFF: rdata_i = 8'h12;
            16'hFFFA: rdata_i = 8'h78;
            16'hFFFB: rdata_i = 8'h56;
            default:  rdata_i = addr_o[7:0] ^ 8'h5A;
        endcase
    end

    intr_entry_seq u_intr_entry_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .kind_i(kind_i),
        .pc_i(pc_i), .sp_i(sp_i),
        .flag_n_i(fn), .flag_v_i(fv), .flag_d_i(fd), .flag_i_i(fi),
        .flag_z_i(fz), .flag_c_i(fc),
        .nmi_pend_i(nmi_pend_i), .rdata_i(rdata_i),
        .addr_o(addr_o), .wdata_o(wdata_o), .we_o(we_o),
        .pc_o(pc_o), .sp_o(sp_o), .i_set_o(i_set_o),
        .nmi_clr_o(nmi_clr_o), .nmi_delay_o(nmi_delay_o),
        .busy_o(busy_o), .done_o(done_o)
    );

    typedef struct {
        logic [15:0] addr;
        logic        we;
        logic [7:0]  wdata;
        logic        iset;
        logic        clr;
        logic        dly;
        logic        done;
        string       tag;
    } item_t;

    item_t exp_q[$];

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            failed++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic add(input logic [15:0] a, input logic w, input logic [7:0] d,
                       input logic is, input logic cl, input logic dl,
                       input logic dn, input string tag);
        item_t it;
        it.addr = a; it.we = w; it.wdata = d; it.iset = is;
        it.clr = cl; it.dly = dl; it.done = dn; it.tag = tag;
        exp_q.push_back(it);
    endtask

    // monitor: one expected item per busy cycle
    always @(negedge clk) begin
        item_t it;
        if (rst_n && busy_o) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R11", "unexpected busy cycle", {16'h0, addr_o}, 32'h0);
            end else begin
                it = exp_q.pop_front();
                chk(addr_o == it.addr && we_o == it.we && (!it.we || wdata_o == it.wdata),
                    it.tag, "bus {addr,we,wdata}",
                    {7'h0, addr_o, we_o, wdata_o}, {7'h0, it.addr, it.we, it.wdata});
                chk({i_set_o, nmi_clr_o, nmi_delay_o, done_o} == {it.iset, it.clr, it.dly, it.done},
                    "R5 R8 R9 R10", "{iset,clr,dly,done}",
                    {28'h0, i_set_o, nmi_clr_o, nmi_delay_o, done_o},
                    {28'h0, it.iset, it.clr, it.dly, it.done});
            end
        end
    end

    task automatic run_seq(input logic [1:0] kind, input logic [15:0] pc,
                           input logic [7:0] sp, input logic [5:0] flags,
                           input logic pend, input bit mid_start);
        logic [15:0] ret, vec, newpc;
        logic        brk, take;
        logic [7:0]  psw;
        int          n;
        brk  = (kind == 2'd2);
        take = brk && pend;
        ret  = brk ? pc + 16'd1 : pc;          // R7
        vec  = (kind == 2'd1 || take) ? 16'hFFFA : 16'hFFFE;  // R6
        newpc = (vec == 16'hFFFA) ? 16'h5678 : 16'h1234;
        psw  = {flags[5], flags[4], 1'b1, brk, flags[3], flags[2], flags[1], flags[0]}; // R4
        add(pc, 1'b0, 8'h00, 0, 0, 0, 0, brk ? "R7" : "R2");
        if (!brk) add(pc, 1'b0, 8'h00, 0, 0, 0, 0, "R2");
        add({8'h01, sp},          1'b1, ret[15:8], 0, 0, 0, 0, "R3");
        add({8'h01, sp - 8'd1},   1'b1, ret[7:0],  0, 0, 0, 0, "R3");
        add({8'h01, sp - 8'd2},   1'b1, psw,       1, take, 0, 0, "R4");
        add(vec,         1'b0, 8'h00, 0, 0, brk && !take, 0, "R6");
        add(vec + 16'd1, 1'b0, 8'h00, 0, 0, 0, 1, "R6");
        n = exp_q.size();
        @(negedge clk);
        kind_i = kind; pc_i = pc; sp_i = sp; nmi_pend_i = pend;
        {fn, fv, fd, fi, fz, fc} = flags;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        pc_i = 16'hDEAD; sp_i = 8'h77;
        if (mid_start) begin
            @(negedge clk);
            start_i = 1'b1; kind_i = 2'd1;     // R11: must be ignored
            @(negedge clk);
            start_i = 1'b0;
            n = n - 2;
        end
        repeat (n) @(negedge clk);
        chk(pc_o == newpc, "R6", "pc_o after done", {16'h0, pc_o}, {16'h0, newpc});
        chk(sp_o == sp - 8'd3, "R3", "sp_o after entry", {24'h0, sp_o}, {24'h0, sp - 8'd3});
        chk(!busy_o && exp_q.size() == 0, "R10", "idle after done",
            {31'h0, busy_o}, 32'h0);
        nmi_pend_i = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failed++; total++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk({busy_o, we_o, done_o, i_set_o, nmi_clr_o, nmi_delay_o} == 6'b0, "R1",
            "reset outputs", {26'h0, busy_o, we_o, done_o, i_set_o, nmi_clr_o, nmi_delay_o}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && !we_o, "R1", "idle after release", {30'h0, busy_o, we_o}, 32'h0);
        // R2 maskable entry
        run_seq(2'd0, 16'h20F0, 8'hFD, 6'b101010, 1'b0, 1'b0);
        // R2 R6 non-maskable entry
        run_seq(2'd1, 16'h8000, 8'h80, 6'b010101, 1'b0, 1'b0);
        // R7 R9 normal break, return address carries into high byte
        run_seq(2'd2, 16'h30FF, 8'hFF, 6'b111111, 1'b0, 1'b0);
        // R8 break taken over by pending NMI
        run_seq(2'd2, 16'h4400, 8'h40, 6'b000000, 1'b1, 1'b0);
        // R8 pending NMI has no effect on a maskable entry
        run_seq(2'd0, 16'h1000, 8'h10, 6'b100001, 1'b1, 1'b0);
        // R3 stack pointer wraps inside the page
        run_seq(2'd1, 16'h0203, 8'h01, 6'b011000, 1'b0, 1'b0);
        // R11 start while busy is ignored
        run_seq(2'd0, 16'hC0DE, 8'hA0, 6'b000100, 1'b0, 1'b1);
        // kind 3 treated as maskable
        run_seq(2'd3, 16'h5555, 8'h33, 6'b001100, 1'b0, 1'b0);
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

endmodule